// File: doc/BRIEF.md
# Byte Read-Modify-Write Sequencer

This block carries out one byte-wide logic operation on memory per accepted command, acting as a simple master on a byte bus. A command carries a 16-bit operation word and three register values: an index register, a base register and a pointer register. For the indexed forms, the byte address is index plus base. The block reads that byte and combines it with an 8-bit immediate taken from the low byte of the word. Depending on the form, it then writes the result back, or only reports a test result. For the test-and-set form, the address is the pointer register. The block reports whether the byte was zero and stores the byte back with its top bit set.

Commands arrive on a valid/ready pair. `op_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where `op_valid` and `op_ready` are both high. Inputs presented while busy are not sampled. On the memory side, each access is a strobe (`bus_rd` or `bus_wr`) held together with its address and write data until the memory raises `bus_ready`. That is the only back-pressure on that side. A test-flag result goes to the core through `flag_we`/`flag_val` in the completion cycle. During test-and-set, `bus_lock` tells the arbiter not to grant the bus to any other master between the read and the write.

Top module: `rmw_byte_seq`

## Requirements
- R1: Operation words whose upper byte is 0xCC (test), 0xCD (and), 0xCE (xor) or 0xCF (or) address the byte at `op_idx + op_base`, truncated to the address width. A word with bits [15:12] = 0x4 and bits [7:0] = 0x1B is test-and-set and addresses the byte at `op_ptr`. In every form the immediate is bits [7:0].
- R2: The and, xor and or forms read the byte once and then write `byte OP imm` once, to the same address.
- R3: The test form reads the byte once and performs no write. It reports flag 1 when `byte & imm` is zero, and flag 0 otherwise.
- R4: Test-and-set reads the byte once and writes `byte | 0x80` to the same address. It reports flag 1 when the byte read was zero, and flag 0 otherwise.
- R5: With zero wait states, `busy` is high for 3 cycles for the test, and, xor and or forms, and for 4 cycles for test-and-set. Each wait cycle on an access adds one cycle. `done` pulses in the last busy cycle, and `busy` is low in the cycle after it.
- R6: `bus_lock` is high in every busy cycle of a test-and-set, from its read until its write is acknowledged. It is never high during any other operation.
- R7: `flag_we` is high only in the `done` cycle of a test or test-and-set operation. The and, xor and or forms never raise it.
- R8: While an access waits for `bus_ready`, its strobe, address and write data stay stable. `bus_rd` and `bus_wr` are never high together.
- R9: `op_ready` is high exactly when `busy` is low. Changes on the command inputs while busy have no effect on the bus traffic or on memory.
- R10: An unrecognized operation word is accepted and completes with `done` after one busy cycle. It makes no bus access and no flag update.
- R11: After reset the block is idle: `op_ready` high, and `busy`, `done`, `bus_rd`, `bus_wr`, `bus_lock` and `flag_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Command present |
| op_ready | output | 1 | Sequencer idle and can take a command |
| op_code | input | 16 | Operation word |
| op_idx | input | AW | Index register value |
| op_base | input | AW | Base register value |
| op_ptr | input | AW | Pointer register value for test-and-set |
| bus_addr | output | AW | Byte address of the current access |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid while `bus_ready` is high |
| bus_ready | input | 1 | Memory completes the current access |
| bus_lock | output | 1 | Keep other masters off the bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completes this cycle |
| flag_we | output | 1 | Test flag update strobe |
| flag_val | output | 1 | New test flag value |

## Verification
The hardest situation to reach from the ports is a stalled access: a read or write that must hold steady for several cycles. In test-and-set this must happen while the lock stays up across the gap. The bench's memory model inserts a programmable number of wait cycles before raising `bus_ready`. Every form is rerun with one to three waits, and the expected busy length is computed from the number of accesses. A second hard case is a command changing while the block is busy. One run holds `op_valid` high with a different command for the whole operation, then checks that only the first command's address was touched.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {K_TEST, K_AND, K_XOR, K_OR, K_TSET, K_BAD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_READ, S_CALC, S_PAD, S_WRITE} state_e;

  function automatic kind_e decode_kind(input logic [15:0] w);
    if (w[15:12] == 4'h4 && w[7:0] == 8'h1B) return K_TSET;
    case (w[15:8])
      8'hCC:   return K_TEST;
      8'hCD:   return K_AND;
      8'hCE:   return K_XOR;
      8'hCF:   return K_OR;
      default: return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [15:0]   word,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ptr,
  output kind_e         kind,
  output logic [7:0]    imm,
  output logic [AW-1:0] addr
);
  always_comb begin
    kind = decode_kind(word);
    imm  = word[7:0];
    addr = (kind == K_TSET) ? ptr : (idx + base);
  end
endmodule

// File: rtl/rmw_combine.sv
module rmw_combine
  import rmw_pkg::*;
(
  input  kind_e      kind,
  input  logic [7:0] rd_byte,
  input  logic [7:0] imm,
  output logic [7:0] wr_byte,
  output logic       flag_val,
  output logic       flag_kind
);
  localparam logic [7:0] TOP_BIT = 8'h80;

  always_comb begin
    case (kind)
      K_AND:   wr_byte = rd_byte & imm;
      K_XOR:   wr_byte = rd_byte ^ imm;
      K_OR:    wr_byte = rd_byte | imm;
      K_TSET:  wr_byte = rd_byte | TOP_BIT;
      default: wr_byte = rd_byte;
    endcase
    flag_val  = (kind == K_TSET) ? (rd_byte == 8'h00) : ((rd_byte & imm) == 8'h00);
    flag_kind = (kind == K_TSET) || (kind == K_TEST);
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  kind_e         dec_kind,
  input  logic [7:0]    dec_imm,
  input  logic [AW-1:0] dec_addr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ready,
  output logic          bus_lock,
  output logic          busy,
  output logic          done,
  output kind_e         kind_q,
  output logic [7:0]    imm_q,
  output logic [7:0]    data_q
);
  state_e        state_q, state_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (op_valid) state_d = (dec_kind == K_BAD) ? S_PAD : S_READ;
      S_READ:  if (bus_ready) state_d = S_CALC;
      S_CALC:  state_d = (kind_q == K_TEST || kind_q == K_TSET) ? S_PAD : S_WRITE;
      S_PAD:   state_d = (kind_q == K_TSET) ? S_WRITE : S_IDLE;
      S_WRITE: if (bus_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_BAD;
      imm_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && op_valid) begin
        kind_q <= dec_kind;
        imm_q  <= dec_imm;
        addr_q <= dec_addr;
      end
      if (state_q == S_READ && bus_ready) data_q <= bus_rdata;
    end
  end

  always_comb begin
    busy     = (state_q != S_IDLE);
    op_ready = (state_q == S_IDLE);
    bus_rd   = (state_q == S_READ);
    bus_wr   = (state_q == S_WRITE);
    bus_addr = addr_q;
    bus_lock = busy && (kind_q == K_TSET);
    done     = (state_q == S_WRITE && bus_ready) || (state_q == S_PAD && kind_q != K_TSET);
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr));
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr));
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && !done |=> bus_lock);
  p_test_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind_q == K_TEST |-> !bus_wr);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> busy);
  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/rmw_byte_seq.sv
module rmw_byte_seq
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [15:0]   op_code,
  input  logic [AW-1:0] op_idx,
  input  logic [AW-1:0] op_base,
  input  logic [AW-1:0] op_ptr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ready,
  output logic          bus_lock,
  output logic          busy,
  output logic          done,
  output logic          flag_we,
  output logic          flag_val
);
  kind_e         dec_kind, kind_q;
  logic [7:0]    dec_imm, imm_q, data_q;
  logic [AW-1:0] dec_addr;
  logic          flag_kind;

  rmw_decode #(.AW(AW)) u_dec (
    .word(op_code), .idx(op_idx), .base(op_base), .ptr(op_ptr),
    .kind(dec_kind), .imm(dec_imm), .addr(dec_addr)
  );

  rmw_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .dec_kind(dec_kind), .dec_imm(dec_imm), .dec_addr(dec_addr),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_lock(bus_lock),
    .busy(busy), .done(done), .kind_q(kind_q), .imm_q(imm_q), .data_q(data_q)
  );

  rmw_combine u_comb (
    .kind(kind_q), .rd_byte(data_q), .imm(imm_q),
    .wr_byte(bus_wdata), .flag_val(flag_val), .flag_kind(flag_kind)
  );

  assign flag_we = done && flag_kind;

  p_tset_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_lock |-> bus_wdata[7]);
  p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ready |=> $stable(bus_wdata));
  p_flag_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> done);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready == !busy);
endmodule

// File: tb/test_rmw_byte_seq.sv
`timescale 1ns/1ps
module test_rmw_byte_seq;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_ready;
  logic [15:0] op_code = 0;
  logic [AW-1:0] op_idx = 0, op_base = 0, op_ptr = 0;
  logic [AW-1:0] bus_addr;
  logic bus_rd, bus_wr, bus_ready, bus_lock, busy, done, flag_we, flag_val;
  logic [7:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  rmw_byte_seq #(.AW(AW)) i_rmw_byte_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_idx(op_idx), .op_base(op_base), .op_ptr(op_ptr),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_lock(bus_lock),
    .busy(busy), .done(done), .flag_we(flag_we), .flag_val(flag_val)
  );

  // memory model with programmable wait states
  logic [7:0] mem [0:255];
  int wait_cfg = 0, wcnt = 0;
  logic pre_en = 0;
  logic [7:0] pre_a = 0, pre_d = 0;
  assign bus_ready = (bus_rd || bus_wr) && (wcnt == wait_cfg);
  assign bus_rdata = mem[bus_addr];
  always @(posedge clk) begin
    if (bus_rd || bus_wr) wcnt <= bus_ready ? 0 : wcnt + 1;
    else wcnt <= 0;
    if (bus_wr && bus_ready) mem[bus_addr] <= bus_wdata;
    else if (pre_en) mem[pre_a] <= pre_d;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pre_en = 1; pre_a = a; pre_d = d;
    @(negedge clk); pre_en = 0;
  endtask

  // observations of the last operation
  int n_busy, n_lock, n_rd, n_wr, n_done, n_stray;
  logic [7:0] rd_a, wr_a, wr_d;
  logic got_we, got_val;

  task automatic run_op(input logic [15:0] code, input logic [7:0] idx,
                        input logic [7:0] base, input logic [7:0] ptr, input bit junk);
    n_busy = 0; n_lock = 0; n_rd = 0; n_wr = 0; n_done = 0; n_stray = 0;
    got_we = 0; got_val = 0; rd_a = 0; wr_a = 0; wr_d = 0;
    @(negedge clk);
    op_code = code; op_idx = idx; op_base = base; op_ptr = ptr; op_valid = 1;
    @(negedge clk);
    if (junk) begin
      op_code = 16'hCF3C; op_idx = 8'hF0; op_base = 8'h0F; op_ptr = 8'hFF;
    end else op_valid = 0;
    for (int k = 0; k < 200; k++) begin
      if (busy) n_busy++;
      if (bus_lock) n_lock++;
      if (flag_we && !done) n_stray++;
      if (bus_rd && bus_ready) begin n_rd++; rd_a = bus_addr; end
      if (bus_wr && bus_ready) begin n_wr++; wr_a = bus_addr; wr_d = bus_wdata; end
      if (done) begin n_done++; got_we = flag_we; got_val = flag_val; break; end
      @(negedge clk);
    end
    op_valid = 0;
    @(negedge clk);
    chk(!busy && op_ready, "R5 idle after done", {busy, op_ready}, 1);
  endtask

  localparam logic [7:0] IMMS [0:7] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hA5, 8'h80, 8'h01, 8'h5A};

  task automatic mem_form(input int f, input logic [7:0] d, input logic [7:0] imm,
                          input logic [7:0] idx, input logic [7:0] base);
    logic [7:0] a, res;
    a = idx + base;
    case (f)
      1: res = d & imm;
      2: res = d ^ imm;
      3: res = d | imm;
      default: res = d;
    endcase
    preload(a, d);
    run_op({8'hCC + 8'(f), imm}, idx, base, 8'h00, 0);
    chk(n_rd == 1 && rd_a == a, "R1 read address", rd_a, a);
    chk(n_done == 1, "R5 done pulse", n_done, 1);
    chk(n_busy == 3 + wait_cfg * ((f == 0) ? 1 : 2), "R5 busy cycles", n_busy,
        3 + wait_cfg * ((f == 0) ? 1 : 2));
    chk(n_lock == 0, "R6 no lock", n_lock, 0);
    chk(n_stray == 0, "R7 stray flag", n_stray, 0);
    if (f == 0) begin
      chk(n_wr == 0, "R3 no write", n_wr, 0);
      chk(mem[a] == d, "R3 memory kept", mem[a], d);
      chk(got_we && got_val == ((d & imm) == 0), "R3 flag", {got_we, got_val},
          {1'b1, (d & imm) == 0});
    end else begin
      chk(n_wr == 1 && wr_a == a, "R2 write address", wr_a, a);
      chk(wr_d == res && mem[a] == res, "R2 write data", wr_d, res);
      chk(!got_we, "R7 no flag update", got_we, 0);
    end
  endtask

  task automatic tset(input logic [7:0] d, input logic [7:0] p);
    logic [15:0] code;
    code = {4'h4, d[3:0], 8'h1B};
    preload(p, d);
    run_op(code, ~p, 8'h33, p, 0);
    chk(n_rd == 1 && rd_a == p, "R1 pointer address", rd_a, p);
    chk(n_wr == 1 && wr_a == p, "R4 write address", wr_a, p);
    chk(wr_d == (d | 8'h80) && mem[p] == (d | 8'h80), "R4 write data", wr_d, d | 8'h80);
    chk(got_we && got_val == (d == 0), "R4 flag", {got_we, got_val}, {1'b1, d == 0});
    chk(n_busy == 4 + 2 * wait_cfg, "R5 busy cycles", n_busy, 4 + 2 * wait_cfg);
    chk(n_lock == n_busy, "R6 lock span", n_lock, n_busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(op_ready && !busy && !done && !bus_rd && !bus_wr && !bus_lock && !flag_we,
        "R11 reset state", {op_ready, busy, done, bus_rd, bus_wr, bus_lock, flag_we}, 7'h40);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R3: every byte value with a set of immediates, all four indexed forms
    for (int f = 0; f < 4; f++)
      for (int d = 0; d < 256; d++)
        for (int i = 0; i < 8; i++)
          mem_form(f, 8'(d), IMMS[i], 8'(d * 7 + f), 8'(8'h90 + i));
    // R4 R6: test-and-set over every byte value
    for (int d = 0; d < 256; d++) tset(8'(d), 8'(d ^ 8'h5A));
    // R8 R5: wait states on every form
    for (int w = 1; w <= 3; w++) begin
      wait_cfg = w;
      for (int f = 0; f < 4; f++) mem_form(f, 8'h3C + 8'(w), 8'hC3, 8'(w * 16), 8'(f));
      tset(8'h00, 8'(w));
      tset(8'h41, 8'(w + 8));
    end
    wait_cfg = 0;
    // R9: command inputs change while busy
    preload(8'hFF, 8'h77);
    preload(8'h20, 8'h0F);
    run_op(16'hCDF0, 8'h10, 8'h10, 8'h00, 1);
    chk(n_rd == 1 && n_wr == 1 && wr_a == 8'h20, "R9 first command only", wr_a, 8'h20);
    chk(mem[8'hFF] == 8'h77, "R9 other address untouched", mem[8'hFF], 8'h77);
    chk(mem[8'h20] == 8'h00, "R9 result", mem[8'h20], 0);
    // R10: unrecognized words
    for (int j = 0; j < 4; j++) begin
      logic [15:0] bad;
      bad = (j == 0) ? 16'hCB12 : (j == 1) ? 16'h0000 : (j == 2) ? 16'h412B : 16'hC8FF;
      run_op(bad, 8'h01, 8'h02, 8'h03, 0);
      chk(n_rd == 0 && n_wr == 0, "R10 no access", n_rd + n_wr, 0);
      chk(n_busy == 1 && n_done == 1, "R10 one cycle", n_busy, 1);
      chk(!got_we, "R10 no flag", got_we, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule